// File: doc/BRIEF.md
# Interrupt Destination Match Logic

This block decides whether one local interrupt unit is a target of an interrupt message sent between processors or routed from elsewhere. Each request carries a two-bit destination shorthand, a physical/logical mode bit, an 8-bit destination field and a flag that says the message was sent by this same unit. The block compares these fields against three programmable registers: a unit ID register, a logical destination register and a destination format register. It returns a match decision.

The three registers are written through a single port. The port has a register select and a per-bit write mask. The format register selects flat or cluster logical addressing. A format code that the block does not recognise gives no logical match and raises a sticky error flag. The match result is registered and comes out one cycle after the request strobe, together with a valid strobe. Interrupt delivery and arbitration between units are left to surrounding logic.

Top module: `dm_dest_match`

## Requirements
- R1: With shorthand 0 (use destination field) and physical mode (`req_logical`=0), `match` is 1 when `req_dest` equals the unit ID or equals 0xFF, and 0 otherwise.
- R2: With shorthand 0, logical mode and a flat format (format register bits 31:28 = 0xF), `match` is 1 when the bitwise AND of the logical ID and `req_dest` is nonzero.
- R3: With shorthand 0, logical mode and a cluster format (bits 31:28 = 0x0), `match` is 1 when the upper nibbles of the logical ID and `req_dest` are equal and the AND of their lower nibbles is nonzero.
- R4: Shorthand 1 (self) matches only when `req_from_self` is 1.
- R5: Shorthand 2 (all including self) always matches.
- R6: Shorthand 3 (all excluding self) matches only when `req_from_self` is 0.
- R7: `reg_sel` selects the register: 0 = ID, 1 = logical destination, 2 = format, and 3 = no register. The unit ID is bits 31:24 of the ID register. The logical ID is bits 31:24 of the logical destination register. The ID register resets to `RESET_ID` in bits 31:24, and the logical destination register resets to 0.
- R8: A write changes only the register bits whose `reg_wmask` bit is 1.
- R9: The format register resets to all ones, which selects the flat format. Every write forces its bits 27:0 to one, so only bits 31:28 select the format.
- R10: A logical request with shorthand 0 under any other format code gives `match` = 0 and sets `fmt_error`. `fmt_error` stays set until reset, and the shorthands 1 to 3 and physical matching keep working.
- R11: `match_valid` is 1 in exactly the cycle after a cycle in which `req_valid` is 1. `match` is 0 whenever `match_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 ID, 1 logical destination, 2 format) |
| reg_wdata | input | 32 | Write data |
| reg_wmask | input | 32 | Per-bit write enable |
| req_valid | input | 1 | Request strobe |
| req_shorthand | input | 2 | Destination shorthand |
| req_logical | input | 1 | 1 = logical destination mode |
| req_dest | input | 8 | Destination field |
| req_from_self | input | 1 | Request was sent by this unit |
| match_valid | output | 1 | Result strobe, one cycle after the request |
| match | output | 1 | This unit is a target |
| fmt_error | output | 1 | Sticky: unrecognised format code was used |

## Verification
The assertions check the following on every cycle:
- the one-cycle valid timing;
- the rule that `match` never appears without `match_valid`;
- that the error flag is sticky;
- that the forced format bits stay at one;
- the fixed outcomes of the self, all and all-but-self shorthands.

Address comparisons depend on programmed register contents, so only the bench scenarios can show them. These cover:
- physical ID equality and broadcast;
- flat and cluster logical matching;
- masked register writes;
- the reset defaults of the registers.

// File: rtl/dm_pkg.sv
package dm_pkg;
  typedef enum logic [1:0] {
    SH_FIELD  = 2'd0,
    SH_SELF   = 2'd1,
    SH_ALL    = 2'd2,
    SH_OTHERS = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    SEL_ID   = 2'd0,
    SEL_LDST = 2'd1,
    SEL_FMT  = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;

  localparam int unsigned MODEL_W = 4;
  localparam logic [MODEL_W-1:0] MODEL_FLAT    = 4'hF;
  localparam logic [MODEL_W-1:0] MODEL_CLUSTER = 4'h0;
endpackage

// File: rtl/dm_cfg_regs.sv
module dm_cfg_regs
  import dm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W = 8,
  parameter logic [ID_W-1:0] RESET_ID = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [1:0]           sel,
  input  logic [DATA_W-1:0]    wdata,
  input  logic [DATA_W-1:0]    wmask,
  output logic [ID_W-1:0]      phys_id,
  output logic [ID_W-1:0]      log_id,
  output logic [MODEL_W-1:0]   model
);
  localparam logic [DATA_W-1:0] FMT_FORCED = {{MODEL_W{1'b0}}, {(DATA_W-MODEL_W){1'b1}}};

  logic [ID_W-1:0]   id_q, id_d, ld_q, ld_d;
  logic [DATA_W-1:0] fmt_q, fmt_d;
  logic              id_en, ld_en, fmt_en;

  always_comb begin
    id_en  = wr_en && (sel == SEL_ID);
    ld_en  = wr_en && (sel == SEL_LDST);
    fmt_en = wr_en && (sel == SEL_FMT);
    id_d   = (id_q & ~wmask[DATA_W-1 -: ID_W]) | (wdata[DATA_W-1 -: ID_W] & wmask[DATA_W-1 -: ID_W]);
    ld_d   = (ld_q & ~wmask[DATA_W-1 -: ID_W]) | (wdata[DATA_W-1 -: ID_W] & wmask[DATA_W-1 -: ID_W]);
    fmt_d  = (fmt_q & ~wmask) | (wdata & wmask) | FMT_FORCED;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q  <= RESET_ID;
      ld_q  <= '0;
      fmt_q <= '1;
    end else begin
      if (id_en)  id_q  <= id_d;
      if (ld_en)  ld_q  <= ld_d;
      if (fmt_en) fmt_q <= fmt_d;
    end
  end

  assign phys_id = id_q;
  assign log_id  = ld_q;
  assign model   = fmt_q[DATA_W-1 -: MODEL_W];

  // R9
  always_ff @(posedge clk) begin
    if (rst_n) begin
      fmt_forced_ones_chk: assert ((fmt_q & FMT_FORCED) == FMT_FORCED)
        else $error("format register low bits not all ones");
    end
  end
endmodule

// File: rtl/dm_logical_match.sv
module dm_logical_match
  import dm_pkg::*;
#(
  parameter int unsigned ID_W = 8
) (
  input  logic [ID_W-1:0]    log_id,
  input  logic [ID_W-1:0]    dest,
  input  logic [MODEL_W-1:0] model,
  output logic               hit,
  output logic               bad_model
);
  localparam int unsigned HALF = ID_W / 2;

  logic flat_hit, cluster_hit;

  always_comb begin
    flat_hit    = |(log_id & dest);
    cluster_hit = (log_id[ID_W-1:HALF] == dest[ID_W-1:HALF]) &&
                  (|(log_id[HALF-1:0] & dest[HALF-1:0]));
    hit       = 1'b0;
    bad_model = 1'b0;
    case (model)
      MODEL_FLAT:    hit = flat_hit;
      MODEL_CLUSTER: hit = cluster_hit;
      default:       bad_model = 1'b1;
    endcase
  end
endmodule

// File: rtl/dm_dest_match.sv
module dm_dest_match
  import dm_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ID_W = 8,
  parameter logic [ID_W-1:0] RESET_ID = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [1:0]        reg_sel,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic [DATA_W-1:0] reg_wmask,
  input  logic              req_valid,
  input  logic [1:0]        req_shorthand,
  input  logic              req_logical,
  input  logic [ID_W-1:0]   req_dest,
  input  logic              req_from_self,
  output logic              match_valid,
  output logic              match,
  output logic              fmt_error
);
  localparam logic [ID_W-1:0] BCAST_ID = '1;

  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic [ID_W-1:0]    phys_id, log_id;
  logic [MODEL_W-1:0] model;
  logic               log_hit, bad_model;
  logic               hit_d, err_d;
  logic               vld_q, match_q, err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  dm_cfg_regs #(.DATA_W(DATA_W), .ID_W(ID_W), .RESET_ID(RESET_ID)) i_cfg (
    .clk(clk), .rst_n(rst_int_n), .wr_en(reg_wr_en), .sel(reg_sel),
    .wdata(reg_wdata), .wmask(reg_wmask),
    .phys_id(phys_id), .log_id(log_id), .model(model)
  );

  dm_logical_match #(.ID_W(ID_W)) i_logic (
    .log_id(log_id), .dest(req_dest), .model(model),
    .hit(log_hit), .bad_model(bad_model)
  );

  always_comb begin
    err_d = err_q;
    case (shorthand_e'(req_shorthand))
      SH_FIELD: begin
        if (req_logical) begin
          hit_d = log_hit;
          if (req_valid && bad_model) err_d = 1'b1;
        end else begin
          hit_d = (req_dest == phys_id) || (req_dest == BCAST_ID);
        end
      end
      SH_SELF:   hit_d = req_from_self;
      SH_ALL:    hit_d = 1'b1;
      default:   hit_d = !req_from_self;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q   <= 1'b0;
      match_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      vld_q   <= req_valid;
      match_q <= req_valid && hit_d;
      err_q   <= err_d;
    end
  end

  assign match_valid = vld_q;
  assign match       = match_q;
  assign fmt_error   = err_q;

  // R11
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid |=> match_valid);
  // R11
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !req_valid |=> !match_valid);
  // R11
  match_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    match |-> match_valid);
  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fmt_error |=> fmt_error);
  // R5
  all_matches_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_shorthand == 2'd2) |=> match);
  // R4
  self_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_shorthand == 2'd1 && !req_from_self) |=> !match);
  // R6
  others_only_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_valid && req_shorthand == 2'd3 && req_from_self) |=> !match);
endmodule

// File: tb/test_dm_dest_match.sv
module test_dm_dest_match;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_wmask;
  logic        req_valid, req_logical, req_from_self;
  logic [1:0]  req_shorthand;
  logic [7:0]  req_dest;
  logic        match_valid, match, fmt_error;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  dm_dest_match #(.RESET_ID(8'h11)) i_dm_dest_match (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_wmask(reg_wmask), .req_valid(req_valid),
    .req_shorthand(req_shorthand), .req_logical(req_logical),
    .req_dest(req_dest), .req_from_self(req_from_self),
    .match_valid(match_valid), .match(match), .fmt_error(fmt_error)
  );

  // {shorthand[2], logical, dest[8], from_self, expected}; ID=0x25, logical ID=0x5A, flat
  localparam logic [12:0] VEC [12] = '{
    {2'd0, 1'b0, 8'h25, 1'b0, 1'b1},  // R1 own ID
    {2'd0, 1'b0, 8'h24, 1'b0, 1'b0},  // R1 other ID
    {2'd0, 1'b0, 8'hFF, 1'b0, 1'b1},  // R1 broadcast
    {2'd0, 1'b1, 8'h02, 1'b0, 1'b1},  // R2 flat overlap
    {2'd0, 1'b1, 8'h05, 1'b0, 1'b0},  // R2 flat disjoint
    {2'd1, 1'b0, 8'h00, 1'b1, 1'b1},  // R4 self from self
    {2'd1, 1'b0, 8'h25, 1'b0, 1'b0},  // R4 self from other
    {2'd2, 1'b0, 8'h00, 1'b0, 1'b1},  // R5 all
    {2'd2, 1'b1, 8'h00, 1'b1, 1'b1},  // R5 all incl self
    {2'd3, 1'b0, 8'h25, 1'b1, 1'b0},  // R6 others from self
    {2'd3, 1'b0, 8'h00, 1'b0, 1'b1},  // R6 others from other
    {2'd0, 1'b1, 8'h00, 1'b0, 1'b0}   // R2 flat zero dest
  };

  task automatic chk(input logic got, input logic exp, input string tag);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_sel = sel; reg_wdata = d; reg_wmask = m;
    @(posedge clk);
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic req(input logic [1:0] sh, input logic lg, input logic [7:0] d,
                     input logic sf, input logic exp, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_shorthand = sh; req_logical = lg; req_dest = d; req_from_self = sf;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(match_valid, 1'b1, {tag, " valid"});
    chk(match, exp, tag);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_sel = 2'd0; reg_wdata = '0; reg_wmask = '0;
    req_valid = 1'b0; req_shorthand = 2'd0; req_logical = 1'b0; req_dest = '0; req_from_self = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk(match_valid, 1'b0, "R11 reset valid");
    chk(match, 1'b0, "R11 reset match");
    chk(fmt_error, 1'b0, "R10 reset error");

    // R7 reset ID 0x11; R9 default flat with logical ID 0
    req(2'd0, 1'b0, 8'h11, 1'b0, 1'b1, "R7 reset ID");
    req(2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, "R7 reset logical ID zero");

    wr(2'd0, 32'h2500_0000, 32'hFFFF_FFFF);
    wr(2'd1, 32'h5A00_0000, 32'hFFFF_FFFF);
    req(2'd1, 1'b1, 8'h5A, 1'b0, 1'b0, "R4 before vectors");
    req(2'd0, 1'b1, 8'h08, 1'b0, 1'b1, "R9 reset format is flat");

    for (int i = 0; i < 12; i++) begin
      req(VEC[i][12:11], VEC[i][10], VEC[i][9:2], VEC[i][1], VEC[i][0],
          $sformatf("vector %0d (R1 R2 R4 R5 R6)", i));
    end

    // R11 idle cycle after request
    @(negedge clk);
    chk(match_valid, 1'b0, "R11 idle valid");

    // R3 cluster, with low bits written as zero (R9 forced)
    wr(2'd2, 32'h0000_0000, 32'hFFFF_FFFF);
    req(2'd0, 1'b1, 8'h52, 1'b0, 1'b1, "R3 same cluster overlap");
    req(2'd0, 1'b1, 8'h62, 1'b0, 1'b0, "R3 other cluster");
    req(2'd0, 1'b1, 8'h55, 1'b0, 1'b0, "R3 same cluster disjoint");
    req(2'd0, 1'b1, 8'h0A, 1'b0, 1'b0, "R3 flat-style dest rejected");

    // R8 masked write: only top nibble of logical ID changes -> 0x3A
    wr(2'd1, 32'h3000_0000, 32'hF000_0000);
    req(2'd0, 1'b1, 8'h38, 1'b0, 1'b1, "R8 masked logical write");
    req(2'd0, 1'b1, 8'h58, 1'b0, 1'b0, "R8 old cluster gone");
    // R8 ID masked: 0x25 -> 0x2F
    wr(2'd0, 32'hFF00_0000, 32'h0F00_0000);
    req(2'd0, 1'b0, 8'h2F, 1'b0, 1'b1, "R8 masked ID write");
    // R7 select 3 writes nothing
    wr(2'd3, 32'h0000_0000, 32'hFFFF_FFFF);
    req(2'd0, 1'b0, 8'h2F, 1'b0, 1'b1, "R7 select 3 ignored");
    // R8 zero mask: format stays cluster
    wr(2'd2, 32'hFFFF_FFFF, 32'h0000_0000);
    req(2'd0, 1'b1, 8'h38, 1'b0, 1'b1, "R8 zero mask format");

    // R10 unknown format
    wr(2'd2, 32'h5000_0000, 32'hFFFF_FFFF);
    chk(fmt_error, 1'b0, "R10 no error before use");
    req(2'd0, 1'b1, 8'hFF, 1'b0, 1'b0, "R10 bad format no match");
    chk(fmt_error, 1'b1, "R10 error set");
    req(2'd0, 1'b0, 8'h2F, 1'b0, 1'b1, "R10 physical still works");
    req(2'd3, 1'b1, 8'h00, 1'b0, 1'b1, "R10 shorthand still works");
    wr(2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    req(2'd0, 1'b1, 8'h02, 1'b0, 1'b1, "R2 flat restored");
    chk(fmt_error, 1'b1, "R10 error sticky");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule